// File: doc/BRIEF.md
# Staged System Reset Sequencer

This block is the reset controller of a small 8-bit microcontroller. It watches a supply-low indication from an analog comparator, the opcode decoder and the memory-access path. From these it drives three outputs: an enable that gates the CPU and module clocks, an active-low external reset pin (brought out as a "drive low" request for an open-drain pad), and a release signal that lets the CPU start its reset-vector fetch. A three-bit status register records which source caused the most recent reset.

A supply-low reset holds everything while the supply is low. Once the supply recovers, the outputs are released in stages: first the clocks after an oscillator settling period, then the pin, and then the CPU. An illegal opcode, a STOP instruction while STOP is not allowed, or an opcode fetch from an unmapped address each trigger a short internal reset. That reset leaves the clocks running, pulls the pin low briefly and then restarts the CPU. A fetch of data from an unmapped address has no effect.

Top module: `rstseq_top`

## Requirements
- R1: During and directly after the synchronous reset `rst`, `clk_hold`=1, `pin_low`=1, `cpu_run`=0 and `rst_status`=0. The first cycle after `rst` drops with `supply_low`=0 starts the same staged release as in R3 to R5, and the status stays 0.
- R2: One cycle after `supply_low` is sampled 1, and for as long as it stays 1, `clk_hold`=1, `pin_low`=1 and `cpu_run`=0. From that cycle `rst_status` reads 3'b001 (bit 0 = supply-low source).
- R3: Let edge 1 be the first edge that samples `supply_low`=0 in the held state. `clk_hold` stays 1 until edge STAB_CYC+1 and is 0 from then on.
- R4: `pin_low` stays 1 until edge STAB_CYC+PIN_DLY+1 and is 0 from then on.
- R5: `cpu_run` becomes 1 at edge STAB_CYC+CPU_DLY+1, with CPU_DLY > PIN_DLY. The pin is always released before the CPU.
- R6: If `supply_low` is sampled 1 at any point of the staged release, all three outputs return to the held state one cycle later. The full sequence of R3 to R5 restarts when the supply recovers.
- R7: While `cpu_run`=1, `op_valid`=1 with `op_illegal`=1 causes an illegal-opcode reset. Let edge 1 be the edge that samples it. `rst_status` becomes 3'b010 (bit 1) and `pin_low`=1 until edge INT_HOLD+1. `cpu_run` returns at edge INT_HOLD+INT_WAIT+1, and `clk_hold` stays 0 throughout.
- R8: `stop_op`=1 with `stop_en`=0 is an illegal-opcode reset as in R7. With `stop_en`=1 it has no effect.
- R9: While running, `acc_vld`=1 with `acc_fetch`=1 and `acc_mapped`=0 causes an illegal-address reset with the R7 timing and `rst_status`=3'b100 (bit 2). A data access (`acc_fetch`=0) or a mapped fetch has no effect.
- R10: At most one status bit is set, and it names the most recent reset source. Without a new reset event the status register does not change.
- R11: Opcode and access inputs are ignored while `cpu_run`=0. When an illegal opcode and an illegal-address fetch occur in the same cycle, the illegal-opcode source is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_low | input | 1 | Supply below trip level |
| op_valid | input | 1 | Opcode decoded this cycle |
| op_illegal | input | 1 | Decoded opcode is not in the instruction set |
| stop_op | input | 1 | STOP instruction decoded this cycle |
| stop_en | input | 1 | Option bit allowing STOP |
| acc_vld | input | 1 | Memory access this cycle |
| acc_fetch | input | 1 | Access is an opcode fetch (0 = data) |
| acc_mapped | input | 1 | Access address is mapped |
| clk_hold | output | 1 | 1 gates CPU and module clocks |
| pin_low | output | 1 | 1 drives the external reset pin low |
| cpu_run | output | 1 | 1 releases the CPU |
| rst_status | output | 3 | Reset source: bit0 supply-low, bit1 opcode, bit2 address |

## Verification
The assertions assume that `supply_low` is a clean synchronous level and that the parameters satisfy CPU_DLY > PIN_DLY. They also assume that the opcode and access strobes are single-cycle pulses, so the R10 stability check may treat any cycle without a supply-low or accepted event as quiet. The bench drives every input at the falling edge. It pulses the strobes for exactly one cycle and sweeps all 128 combinations of the seven opcode/access inputs from the running state. It also reasserts the supply-low input at every offset of the staged release.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        PH_LOWV  = 3'd0,
        PH_STAB  = 3'd1,
        PH_PINW  = 3'd2,
        PH_CPUW  = 3'd3,
        PH_RUN   = 3'd4,
        PH_IHOLD = 3'd5,
        PH_IWAIT = 3'd6
    } phase_t;

    typedef struct packed {
        logic addr_err;
        logic opc_err;
        logic lowv;
    } rst_stat_t;

    typedef struct packed {
        logic opc;
        logic addr;
    } int_evt_t;

    typedef struct packed {
        logic hold;
        logic pin;
        logic run;
    } seq_out_t;

    function automatic int max5(input int a, input int b, input int c,
                                input int d, input int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

    function automatic seq_out_t phase_outs(input phase_t ph);
        seq_out_t o;
        case (ph)
            PH_PINW:  o = '{hold: 1'b0, pin: 1'b1, run: 1'b0};
            PH_CPUW:  o = '{hold: 1'b0, pin: 1'b0, run: 1'b0};
            PH_RUN:   o = '{hold: 1'b0, pin: 1'b0, run: 1'b1};
            PH_IHOLD: o = '{hold: 1'b0, pin: 1'b1, run: 1'b0};
            PH_IWAIT: o = '{hold: 1'b0, pin: 1'b0, run: 1'b0};
            default:  o = '{hold: 1'b1, pin: 1'b1, run: 1'b0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/rstseq_event.sv
module rstseq_event
    import rstseq_pkg::*;
(
    input  logic     cpu_run,
    input  logic     supply_low,
    input  logic     op_valid,
    input  logic     op_illegal,
    input  logic     stop_op,
    input  logic     stop_en,
    input  logic     acc_vld,
    input  logic     acc_fetch,
    input  logic     acc_mapped,
    output int_evt_t evt
);

    logic bad_opc;
    logic bad_addr;
    logic accept;

    always_comb begin
        bad_opc  = (op_valid & op_illegal) | (stop_op & ~stop_en);
        bad_addr = acc_vld & acc_fetch & ~acc_mapped;
        accept   = cpu_run & ~supply_low;
        evt.opc  = accept & bad_opc;
        evt.addr = accept & bad_addr & ~bad_opc;
    end

endmodule

// File: rtl/rstseq_status.sv
module rstseq_status
    import rstseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      supply_low,
    input  int_evt_t  evt,
    output rst_stat_t stat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (supply_low) begin
            stat <= '{addr_err: 1'b0, opc_err: 1'b0, lowv: 1'b1};
        end else if (evt.opc) begin
            stat <= '{addr_err: 1'b0, opc_err: 1'b1, lowv: 1'b0};
        end else if (evt.addr) begin
            stat <= '{addr_err: 1'b1, opc_err: 1'b0, lowv: 1'b0};
        end
    end

    // R10
    one_source_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stat));

    // R10
    status_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!supply_low && !evt.opc && !evt.addr) |=> $stable(stat));

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int STAB_CYC = 4096,
    parameter int PIN_DLY  = 32,
    parameter int CPU_DLY  = 64,
    parameter int INT_HOLD = 32,
    parameter int INT_WAIT = 32
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     supply_low,
    input  int_evt_t evt,
    output seq_out_t outs
);

    localparam int CMAX = max5(STAB_CYC, PIN_DLY, CPU_DLY, INT_HOLD, INT_WAIT);
    localparam int CW   = $clog2(CMAX + 1);

    localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYC - 1);
    localparam logic [CW-1:0] PIN_LAST  = CW'(PIN_DLY - 1);
    localparam logic [CW-1:0] CPU_LAST  = CW'(CPU_DLY - 1);
    localparam logic [CW-1:0] IH_LAST   = CW'(INT_HOLD - 1);
    localparam logic [CW-1:0] IW_LAST   = CW'(INT_WAIT - 1);

    phase_t         ph;
    logic [CW-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst || supply_low) begin
            ph  <= PH_LOWV;
            cnt <= '0;
        end else begin
            case (ph)
                PH_LOWV: begin
                    ph  <= PH_STAB;
                    cnt <= '0;
                end
                PH_STAB: begin
                    if (cnt == STAB_LAST) begin
                        ph  <= PH_PINW;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_PINW: begin
                    if (cnt == PIN_LAST) ph <= PH_CPUW;
                    cnt <= cnt + 1'b1;
                end
                PH_CPUW: begin
                    if (cnt == CPU_LAST) begin
                        ph  <= PH_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_RUN: begin
                    if (evt.opc || evt.addr) begin
                        ph  <= PH_IHOLD;
                        cnt <= '0;
                    end
                end
                PH_IHOLD: begin
                    if (cnt == IH_LAST) begin
                        ph  <= PH_IWAIT;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_IWAIT: begin
                    if (cnt == IW_LAST) begin
                        ph  <= PH_RUN;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    ph  <= PH_LOWV;
                    cnt <= '0;
                end
            endcase
        end
    end

    always_comb outs = phase_outs(ph);

    // R2
    lowv_holds_all_chk: assert property (@(posedge clk) disable iff (rst)
        supply_low |=> (outs.hold && outs.pin && !outs.run));

    // R3
    clk_first_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(outs.hold) |-> (outs.pin && !outs.run));

    // R5
    pin_before_cpu_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(outs.pin) |-> !outs.run);

    // R7
    int_from_run_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(outs.pin) && !outs.hold) |-> $past(outs.run));

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int STAB_CYC = 4096,
    parameter int PIN_DLY  = 32,
    parameter int CPU_DLY  = 64,
    parameter int INT_HOLD = 32,
    parameter int INT_WAIT = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       supply_low,
    input  logic       op_valid,
    input  logic       op_illegal,
    input  logic       stop_op,
    input  logic       stop_en,
    input  logic       acc_vld,
    input  logic       acc_fetch,
    input  logic       acc_mapped,
    output logic       clk_hold,
    output logic       pin_low,
    output logic       cpu_run,
    output logic [2:0] rst_status
);

    int_evt_t  evt;
    seq_out_t  outs;
    rst_stat_t stat;

    rstseq_event evt_i (
        .cpu_run    (outs.run),
        .supply_low (supply_low),
        .op_valid   (op_valid),
        .op_illegal (op_illegal),
        .stop_op    (stop_op),
        .stop_en    (stop_en),
        .acc_vld    (acc_vld),
        .acc_fetch  (acc_fetch),
        .acc_mapped (acc_mapped),
        .evt        (evt)
    );

    rstseq_fsm #(
        .STAB_CYC (STAB_CYC),
        .PIN_DLY  (PIN_DLY),
        .CPU_DLY  (CPU_DLY),
        .INT_HOLD (INT_HOLD),
        .INT_WAIT (INT_WAIT)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .supply_low (supply_low),
        .evt        (evt),
        .outs       (outs)
    );

    rstseq_status stat_i (
        .clk        (clk),
        .rst        (rst),
        .supply_low (supply_low),
        .evt        (evt),
        .stat       (stat)
    );

    assign clk_hold   = outs.hold;
    assign pin_low    = outs.pin;
    assign cpu_run    = outs.run;
    assign rst_status = stat;

endmodule

// File: tb/rstseq_top_tb.sv
module rstseq_top_tb_top;

    localparam int S  = 16;
    localparam int P  = 4;
    localparam int C  = 8;
    localparam int IH = 4;
    localparam int IW = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst, supply_low, op_valid, op_illegal, stop_op, stop_en;
    logic       acc_vld, acc_fetch, acc_mapped;
    logic       clk_hold, pin_low, cpu_run;
    logic [2:0] rst_status;

    int  errs   = 0;
    int  checks = 0;
    logic [2:0] exp_stat;

    rstseq_top #(
        .STAB_CYC (S), .PIN_DLY (P), .CPU_DLY (C),
        .INT_HOLD (IH), .INT_WAIT (IW)
    ) dut_i (
        .clk (clk), .rst (rst), .supply_low (supply_low),
        .op_valid (op_valid), .op_illegal (op_illegal),
        .stop_op (stop_op), .stop_en (stop_en),
        .acc_vld (acc_vld), .acc_fetch (acc_fetch), .acc_mapped (acc_mapped),
        .clk_hold (clk_hold), .pin_low (pin_low), .cpu_run (cpu_run),
        .rst_status (rst_status)
    );

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_ins();
        op_valid = 0; op_illegal = 0; stop_op = 0;
        acc_vld = 0; acc_fetch = 0; acc_mapped = 0;
    endtask

    task automatic held(input string req);
        chk({req, " clk_hold"}, clk_hold, 1);
        chk({req, " pin_low"}, pin_low, 1);
        chk({req, " cpu_run"}, cpu_run, 0);
    endtask

    // supply_low already 0 at a falling edge; edge k=1 is the next one.
    // inj_k > 0 pulses illegal opcode + unmapped fetch on that edge (R11).
    task automatic lv_timeline(input string tag, input int inj_k);
        for (int k = 1; k <= S + C + 2; k++) begin
            if (k == inj_k) begin
                op_valid = 1; op_illegal = 1; stop_op = 1;
                acc_vld = 1; acc_fetch = 1; acc_mapped = 0;
            end
            step();
            clear_ins();
            chk({tag, " R3 clk_hold"}, clk_hold, (k < 1 + S) ? 1 : 0);
            chk({tag, " R4 pin_low"}, pin_low, (k < 1 + S + P) ? 1 : 0);
            chk({tag, " R5 cpu_run"}, cpu_run, (k >= 1 + S + C) ? 1 : 0);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        rst = 1; supply_low = 0; stop_en = 0;
        clear_ins();
        repeat (3) step();
        // R1 reset state
        held("R1 reset");
        chk("R1 status", rst_status, 3'b000);
        rst = 0;
        lv_timeline("R1 power-on", 0);
        chk("R1 status after power-on", rst_status, 3'b000);

        // R2 held while supply low
        supply_low = 1;
        for (int i = 0; i < 5; i++) begin
            step();
            held("R2 supply low");
            chk("R2 status", rst_status, 3'b001);
        end
        supply_low = 0;
        lv_timeline("R2 recovery", 0);

        // R6 reassert at every offset of the release
        for (int r = 1; r <= S + C; r++) begin
            supply_low = 1;
            step();
            supply_low = 0;
            for (int i = 0; i < r; i++) step();
            supply_low = 1;
            step();
            held("R6 reassert");
            chk("R6 status", rst_status, 3'b001);
            supply_low = 0;
        end
        lv_timeline("R6 full restart", 0);

        // R11 events ignored while CPU held
        supply_low = 1;
        step();
        supply_low = 0;
        lv_timeline("R11 ignored", S + P + 2);
        chk("R11 status unchanged", rst_status, 3'b001);
        exp_stat = 3'b001;

        // R7 R8 R9 R10 R11 sweep over all opcode/access combinations
        for (int v = 0; v < 128; v++) begin
            logic ilop, ilad;
            op_valid   = v[0]; op_illegal = v[1]; stop_op   = v[2];
            stop_en    = v[3]; acc_vld    = v[4]; acc_fetch = v[5];
            acc_mapped = v[6];
            ilop = (v[0] & v[1]) | (v[2] & ~v[3]);
            ilad = v[4] & v[5] & ~v[6];
            step();
            clear_ins();
            if (ilop) exp_stat = 3'b010;
            else if (ilad) exp_stat = 3'b100;
            chk("R10 status source", rst_status, exp_stat);
            if (ilop || ilad) begin
                for (int k = 1; k <= IH + IW + 1; k++) begin
                    if (k > 1) step();
                    chk("R7 clk_hold", clk_hold, 0);
                    chk("R7 pin_low", pin_low, (k < 1 + IH) ? 1 : 0);
                    chk("R9 cpu_run", cpu_run, (k >= 1 + IH + IW) ? 1 : 0);
                end
            end else begin
                chk("R8 no reset cpu_run", cpu_run, 1);
                chk("R9 no reset pin_low", pin_low, 0);
            end
        end
        chk("R10 final status", rst_status, exp_stat);

        finish_run();
    end

endmodule